// File: doc/BRIEF.md
# Smart Card Bit Period Timer

This block produces the bit timing for a serial smart card link. It counts pulses of a card-clock enable. It raises a one-cycle bit strobe at the end of every elementary time unit (ETU), and a one-cycle sample strobe near the middle of each ETU. The ETU spans F/D card-clock pulses. F is a clock rate conversion factor and D is a bit rate adjustment factor. After reset, the block runs with F = 372 and D = 1, which are the values used during the answer-to-reset phase. One ETU then lasts exactly 372 card clocks, so the bit rate is the card clock divided by 372. For card clocks from 1 MHz to 5 MHz, that gives roughly 2.7 to 13.4 kbit/s.

A controller writes new factors with a load pulse. They are held in a staging register and become active only at a bit boundary, so a bit in progress never changes length. When F is not a multiple of D, the remainder of the division carries from bit to bit, and the bit edges stay on the ideal grid. A restart pulse realigns the timer to the start edge of an incoming character.

Top module: `sc_etu_timer`

## Requirements
- R1: After reset, `f_act` reads 372 and `d_act` reads 1, and both strobes are low. With no load, the first bit strobe follows the 372nd enable pulse, and so does every later one.
- R2: A bit is floor(F/D) or floor(F/D)+1 enable pulses long. The remainder of F/D is carried between bits, so the k-th bit strobe after a boundary where the factors changed (or after a restart) follows enable pulse number floor(k*F/D).
- R3: The sample strobe follows the enable pulse numbered floor(L/2) within a bit of length L, counted from the bit's start. It never coincides with a bit strobe.
- R4: Both strobes are single-cycle pulses. Each appears in the clock cycle after the enable pulse that triggers it.
- R5: A load pulse captures `f_in` and `d_in` into staging. The staged values are copied to `f_act`/`d_act`, and used for timing, only at the next bit boundary (a bit-end enable pulse or a restart). At a bit end they change in the same cycle as the bit strobe. A load in the same cycle as a boundary waits for the following boundary.
- R6: A load with `d_in` equal to zero leaves the staged D unchanged, while F is still captured. `d_act` is never zero.
- R7: A restart clears the pulse count and the carried remainder, and applies staged factors. No strobe results from the restart cycle, even if the enable is high, and the first bit strobe follows enable pulse floor(F/D).
- R8: When floor(F/D) is below 2, every bit is exactly 2 enable pulses long, with no remainder carry.
- R9: Cycles without an enable pulse advance nothing and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | One pulse per card-clock cycle |
| restart | input | 1 | Realign the timer to a character start |
| load | input | 1 | Capture `f_in`/`d_in` into staging |
| f_in | input | FW (12) | New clock rate conversion factor |
| d_in | input | DW (4) | New bit rate adjustment factor; zero is ignored |
| bit_stb | output | 1 | End-of-ETU strobe |
| smp_stb | output | 1 | Mid-bit sample strobe |
| f_act | output | FW (12) | F value now in use |
| d_act | output | DW (4) | D value now in use |

## Verification
Some properties are checked on every cycle: each strobe needs an enable pulse in the previous cycle, a restart produces no strobe, the two strobes never coincide, the active factors change only alongside a bit strobe or after a restart, and D never becomes zero. Other behaviour shows only in the bench's sweeps over F and D, with and without gaps in the enable. These are the exact placement of each bit edge on the floor(k*F/D) grid, the mid-bit sample position, the clamp for short quotients, mid-bit loads, rejected zero D values, and restarts in the middle of a bit.

// File: rtl/sc_etu_pkg.sv
package sc_etu_pkg;

   // shortest ETU the counter will produce, in enable pulses
   localparam int unsigned MIN_ETU = 2;

   function automatic int unsigned clamp_len(input int unsigned q);
      return (q < MIN_ETU) ? MIN_ETU : q;
   endfunction

endpackage

// File: rtl/sc_etu_fdreg.sv
// Staged and active F/D factor registers.
module sc_etu_fdreg #(
   parameter int unsigned FW    = 12,
   parameter int unsigned DW    = 4,
   parameter int unsigned DEF_F = 372,
   parameter int unsigned DEF_D = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FW-1:0] f_in,
   input  logic [DW-1:0] d_in,
   input  logic          apply,
   output logic [FW-1:0] f_act,
   output logic [DW-1:0] d_act,
   output logic [FW-1:0] f_stg,
   output logic [DW-1:0] d_stg,
   output logic          chg
);

   localparam logic [FW-1:0] RST_F = FW'(DEF_F);
   localparam logic [DW-1:0] RST_D = DW'(DEF_D);

   logic d_ok;
   assign d_ok = (d_in != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_act <= RST_F;
         d_act <= RST_D;
         f_stg <= RST_F;
         d_stg <= RST_D;
      end else begin
         if (apply) begin
            f_act <= f_stg;
            d_act <= d_stg;
         end
         if (load) begin
            f_stg <= f_in;
            if (d_ok) begin
               d_stg <= d_in;
            end
         end
      end
   end

   assign chg = (f_stg != f_act) || (d_stg != d_act);

endmodule

// File: rtl/sc_etu_div.sv
// Quotient and remainder of F/D; D is never zero.
module sc_etu_div #(
   parameter int unsigned FW = 12,
   parameter int unsigned DW = 4
) (
   input  logic [FW-1:0] f,
   input  logic [DW-1:0] d,
   output logic [FW-1:0] q,
   output logic [DW-1:0] r
);

   generate
      if (DW == 1) begin : g_unit
         // a one-bit nonzero D can only be 1
         assign q = f;
         assign r = '0;
      end else begin : g_div
         logic [FW-1:0] d_ext;
         logic [FW-1:0] rem;
         assign d_ext = FW'(d);
         assign q     = f / d_ext;
         assign rem   = f % d_ext;
         assign r     = rem[DW-1:0];
      end
   endgenerate

endmodule

// File: rtl/sc_etu_cnt.sv
// Pulse counter, remainder carry and strobe generation.
module sc_etu_cnt #(
   parameter int unsigned LW      = 13,
   parameter int unsigned DW      = 4,
   parameter int unsigned RST_LEN = 372
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          restart,
   input  logic          chg,
   input  logic [LW-1:0] q,
   input  logic [DW-1:0] r,
   input  logic [DW-1:0] d,
   output logic          bnd,
   output logic          bit_stb,
   output logic          smp_stb
);

   import sc_etu_pkg::*;

   localparam logic [LW-1:0] MIN_LEN = LW'(MIN_ETU);
   localparam logic [LW-1:0] INI_LEN = LW'(RST_LEN);

   logic [LW-1:0] cnt, cur_len, nxt_len, half;
   logic [DW-1:0] acc, acc_base, nxt_acc;
   logic [DW:0]   sum;
   logic          bit_end, smp_hit;

   assign half    = cur_len >> 1;
   assign bit_end = clk_en && !restart && (cnt == cur_len - 1'b1);
   assign smp_hit = clk_en && !restart && (cnt == half - 1'b1);
   assign bnd     = restart || bit_end;

   always_comb begin
      acc_base = (restart || chg) ? '0 : acc;
      sum      = {1'b0, acc_base} + {1'b0, r};
      if (q < MIN_LEN) begin
         nxt_len = MIN_LEN;
         nxt_acc = '0;
      end else if (sum >= {1'b0, d}) begin
         nxt_len = q + 1'b1;
         nxt_acc = DW'(sum - {1'b0, d});
      end else begin
         nxt_len = q;
         nxt_acc = sum[DW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         cur_len <= INI_LEN;
         acc     <= '0;
         bit_stb <= 1'b0;
         smp_stb <= 1'b0;
      end else begin
         bit_stb <= bit_end;
         smp_stb <= smp_hit;
         if (bnd) begin
            cnt     <= '0;
            cur_len <= nxt_len;
            acc     <= nxt_acc;
         end else if (clk_en) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int unsigned FW    = 12,
   parameter int unsigned DW    = 4,
   parameter int unsigned DEF_F = 372,
   parameter int unsigned DEF_D = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          restart,
   input  logic          load,
   input  logic [FW-1:0] f_in,
   input  logic [DW-1:0] d_in,
   output logic          bit_stb,
   output logic          smp_stb,
   output logic [FW-1:0] f_act,
   output logic [DW-1:0] d_act
);

   import sc_etu_pkg::*;

   localparam int unsigned LW      = FW + 1;
   localparam int unsigned RST_LEN = clamp_len(DEF_F / DEF_D);

   generate
      if (DEF_D == 0) begin : g_bad_d
         $error("sc_etu_timer: DEF_D must be nonzero");
      end
      if (DEF_D >= (1 << DW)) begin : g_bad_dw
         $error("sc_etu_timer: DEF_D does not fit DW");
      end
      if (DEF_F >= (1 << FW)) begin : g_bad_fw
         $error("sc_etu_timer: DEF_F does not fit FW");
      end
      if (FW < DW) begin : g_bad_w
         $error("sc_etu_timer: FW must be at least DW");
      end
   endgenerate

   logic [FW-1:0] f_stg, q;
   logic [DW-1:0] d_stg, r;
   logic          chg, bnd;

   sc_etu_fdreg #(.FW(FW), .DW(DW), .DEF_F(DEF_F), .DEF_D(DEF_D)) i_fdreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .f_in  (f_in),
      .d_in  (d_in),
      .apply (bnd),
      .f_act (f_act),
      .d_act (d_act),
      .f_stg (f_stg),
      .d_stg (d_stg),
      .chg   (chg)
   );

   sc_etu_div #(.FW(FW), .DW(DW)) i_div (
      .f (f_stg),
      .d (d_stg),
      .q (q),
      .r (r)
   );

   sc_etu_cnt #(.LW(LW), .DW(DW), .RST_LEN(RST_LEN)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .restart (restart),
      .chg     (chg),
      .q       (LW'(q)),
      .r       (r),
      .d       (d_stg),
      .bnd     (bnd),
      .bit_stb (bit_stb),
      .smp_stb (smp_stb)
   );

endmodule

// File: rtl/sc_etu_chk.sv
module sc_etu_chk #(
   parameter int unsigned FW = 12,
   parameter int unsigned DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en,
   input logic          restart,
   input logic          bit_stb,
   input logic          smp_stb,
   input logic [FW-1:0] f_act,
   input logic [DW-1:0] d_act
);

   p_stb_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb || smp_stb) |-> ($past(clk_en) && !$past(restart)));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clk_en) |-> (!bit_stb && !smp_stb));

   p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart) |-> (!bit_stb && !smp_stb));

   p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_stb && smp_stb));

   p_fd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && !$past(restart)) |-> ($stable(f_act) && $stable(d_act)));

   p_d_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      d_act != '0);

endmodule

bind sc_etu_timer sc_etu_chk #(.FW(FW), .DW(DW)) i_sc_etu_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clk_en  (clk_en),
   .restart (restart),
   .bit_stb (bit_stb),
   .smp_stb (smp_stb),
   .f_act   (f_act),
   .d_act   (d_act)
);

// File: tb/test_sc_etu_timer.sv
module test_sc_etu_timer;

   localparam int FW = 12;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic          restart = 1'b0;
   logic          load = 1'b0;
   logic [FW-1:0] f_in = '0;
   logic [DW-1:0] d_in = '0;
   logic          bit_stb, smp_stb;
   logic [FW-1:0] f_act;
   logic [DW-1:0] d_act;

   int vec = 0;
   int bad = 0;
   int cycles = 0;

   sc_etu_timer i_sc_etu_timer (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .restart(restart),
      .load(load), .f_in(f_in), .d_in(d_in), .bit_stb(bit_stb),
      .smp_stb(smp_stb), .f_act(f_act), .d_act(d_act)
   );

   always #5 clk = ~clk;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 190000) begin
         bad++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input bit en, input bit ld, input bit rs);
      clk_en = en; load = ld; restart = rs;
      @(negedge clk);
      clk_en = 1'b0; load = 1'b0; restart = 1'b0;
   endtask

   function automatic int edge_at(input int f, input int d, input int k);
      if (f / d < 2) return 2 * k;
      return (k * f) / d;
   endfunction

   // nb bits from a fresh boundary; gap inserts idle cycles between pulses
   task automatic run_bits(input int f, input int d, input int nb, input bit gap);
      int n = 0, k = 1, bp = 0, s = 0;
      int bk = edge_at(f, d, 1);
      string tg = (f / d < 2) ? "R8" : "R2";
      while (k <= nb && s < 20000) begin
         bit en = gap ? (s % 2 == 0) : 1'b1;
         bit eb, es;
         s++;
         step(en, 1'b0, 1'b0);
         if (en) n++;
         eb = en && (n == bk);
         es = en && (n == bp + (bk - bp) / 2);
         chk(bit_stb == eb, en ? tg : "R9 bit", int'(bit_stb), int'(eb));
         chk(smp_stb == es, en ? "R3 sample" : "R9 sample", int'(smp_stb), int'(es));
         if (eb) begin
            chk(f_act == f, "R5 f_act", int'(f_act), f);
            bp = bk;
            k++;
            bk = edge_at(f, d, k);
         end
      end
   endtask

   task automatic load_cfg(input int f, input int d, input int ed);
      f_in = FW'(f); d_in = DW'(d);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      chk(f_act == f, "R5 f after restart", int'(f_act), f);
      chk(d_act == ed, "R6 d after restart", int'(d_act), ed);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and default timing
      chk(f_act == 372, "R1 f reset", int'(f_act), 372);
      chk(d_act == 1, "R1 d reset", int'(d_act), 1);
      chk(!bit_stb && !smp_stb, "R1 strobes", int'({bit_stb, smp_stb}), 0);
      run_bits(372, 1, 2, 1'b0);

      // R2 R3 R8 R9 sweep over F and D, with and without enable gaps
      for (int d = 1; d <= 5; d++) begin
         for (int f = 1; f <= 24; f++) begin
            load_cfg(f, d, d);
            run_bits(f, d, (2 * d < 3) ? 3 : 2 * d, ((f + d) % 2) == 1);
         end
      end
      load_cfg(3, 2, 2);
      run_bits(3, 2, 4, 1'b0);  // R8 explicit

      // R5 mid-bit load: F=20 D=1 running, new 10/2 waits for bit end
      load_cfg(20, 1, 1);
      repeat (5) step(1'b1, 1'b0, 1'b0);
      f_in = 10; d_in = 2;
      step(1'b1, 1'b1, 1'b0);
      for (int p = 7; p <= 19; p++) step(1'b1, 1'b0, 1'b0);
      chk(f_act == 20 && !bit_stb, "R5 hold mid-bit", int'(f_act), 20);
      step(1'b1, 1'b0, 1'b0);
      chk(bit_stb == 1'b1, "R5 old length kept", int'(bit_stb), 1);
      chk(f_act == 10, "R5 f at boundary", int'(f_act), 10);
      chk(d_act == 2, "R5 d at boundary", int'(d_act), 2);
      run_bits(10, 2, 2, 1'b0);

      // R6 zero D is ignored, F still taken
      load_cfg(30, 0, 2);
      run_bits(30, 2, 2, 1'b0);

      // R7 restart mid-bit with enable high, carry cleared
      load_cfg(7, 3, 3);
      repeat (3) step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      chk(!bit_stb && !smp_stb, "R7 restart quiet", int'({bit_stb, smp_stb}), 0);
      run_bits(7, 3, 6, 1'b0);
      load_cfg(12, 1, 1);
      repeat (5) step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      chk(!bit_stb && !smp_stb, "R7 restart realign", int'({bit_stb, smp_stb}), 0);
      run_bits(12, 1, 2, 1'b1);

      summary();
      $finish;
   end

endmodule